// File: doc/BRIEF.md
# Privilege-Qualified Address Window Guard

This block sits beside the memory port of a small processor and enforces hardware protection. It holds a one-bit privilege mode, a window origin register and a window size register, and it judges every memory access against that window while the processor runs in user mode. In supervisor (monitor) mode every access is let through without a range check. The block also owns a down-counting supervisory timer. The timer raises an interrupt when it runs out, so the operating system regains control even from a user program that never yields.

Loading the origin, size or timer is privileged, and so are I/O instructions. Any such attempt made from user mode is refused: the target register keeps its value and a one-cycle protection fault is raised. Every fault, every external interrupt and every timer expiry drops the processor back to monitor mode. Software leaves monitor mode explicitly, with the enter-user request, before it returns to a user program.

Top module: `prot_guard_unit`

## Requirements
- R1: After reset the mode is monitor (`user_mode_o` = 0), `prot_fault_o` = 0, `timer_irq_o` = 0, the origin and size registers are 0, and the timer is disarmed.
- R2: In monitor mode, every access with `acc_valid_i` = 1 is permitted in the same cycle, whatever its address, and it never raises a fault.
- R3: In user mode, an access is permitted in the same cycle exactly when origin <= address < origin + size. The sum is formed one bit wider than the address, so a window that reaches the top of the address space does not wrap. A size of 0 permits nothing.
- R4: A user-mode access outside the window is refused in its own cycle. `prot_fault_o` is 1 for exactly the following cycle, and in that same following cycle the mode is monitor.
- R5: Write select codes are 0 = origin, 1 = size, 2 = timer, and 3 = no register. A write with select 0, 1 or 2 takes effect in monitor mode. Made in user mode, the same write leaves its register unchanged, gives a one-cycle fault in the next cycle and switches to monitor. Select 3 never has any effect.
- R6: `io_req_i` in user mode gives a one-cycle fault in the next cycle and switches to monitor. In monitor mode it has no effect.
- R7: `enter_user_i` in monitor mode switches to user mode at the next edge. A fault, `ext_irq_i` or a timer expiry in the same cycle takes priority and leaves the mode at monitor. `ext_irq_i` switches to monitor without raising a fault.
- R8: A timer load of N > 0 sets the count to N at the write edge. The count then decrements once per clock, and `timer_irq_o` rises in the cycle after the Nth following edge.
- R9: Once expired, the timer stops at zero and holds `timer_irq_o` high until it is reloaded. A reload with a nonzero value clears the interrupt at the write edge.
- R10: In the cycle in which `timer_irq_o` first rises, the mode is monitor.
- R11: With `acc_valid_i` = 0, `acc_permit_o` is 0 and no range fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 1 | External interrupt; forces monitor mode |
| enter_user_i | input | 1 | Request to switch to user mode |
| io_req_i | input | 1 | The processor is issuing an I/O instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 origin, 1 size, 2 timer, 3 none |
| wr_data_i | input | AW | Write data |
| acc_valid_i | input | 1 | A memory access is presented |
| acc_addr_i | input | AW | Physical address of the access |
| user_mode_o | output | 1 | 1 = user mode, 0 = monitor mode |
| acc_permit_o | output | 1 | The access may proceed (combinational) |
| prot_fault_o | output | 1 | One-cycle protection fault |
| timer_irq_o | output | 1 | Supervisory timer expired |

## Verification
The window check is driven with addresses one below the origin, at the origin, at the last legal address and at origin plus size. These four separate an off-by-one at either bound from a correct compare. A window that ends past the top of the address space tells a wide sum from a truncated one, because a wrapped sum refuses the high addresses. Privileged writes are attempted in user mode and then followed by legal accesses, which shows at the ports that the old window survived. Timer loads of two different lengths pin down the exact expiry cycle and show that the interrupt holds until reload.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic {
        MODE_MONITOR = 1'b0,
        MODE_USER    = 1'b1
    } prot_mode_e;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_TIMER = 2'd2,
        SEL_NONE  = 2'd3
    } prot_sel_e;

endpackage

// File: rtl/prot_mode_ctrl.sv
module prot_mode_ctrl
    import prot_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trap_i,
    input  logic enter_user_i,
    output logic user_o
);

    typedef struct packed {
        prot_mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    // Traps win over a return to user mode.
    always_comb begin
        st_d = st_q;
        if (trap_i) begin
            st_d.mode = MODE_MONITOR;
        end else if (enter_user_i) begin
            st_d.mode = MODE_USER;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_MONITOR};
        end else begin
            st_q <= st_d;
        end
    end

    assign user_o = (st_q.mode == MODE_USER);

    assert_trap_monitor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> !user_o);

    assert_enter_user_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enter_user_i && !trap_i) |=> user_o);

endmodule

// File: rtl/prot_bound_chk.sv
module prot_bound_chk #(
    parameter int AW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_base_i,
    input  logic          wr_limit_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [AW-1:0] addr_i,
    output logic          in_window_o
);

    localparam int EW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
    } bound_state_t;

    bound_state_t  st_d, st_q;
    logic [EW-1:0] win_end;

    always_comb begin
        st_d = st_q;
        if (wr_base_i) begin
            st_d.base = wr_data_i;
        end
        if (wr_limit_i) begin
            st_d.limit = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Window end is one bit wider than an address, so it never wraps.
    assign win_end     = {1'b0, st_q.base} + {1'b0, st_q.limit};
    assign in_window_o = (addr_i >= st_q.base) && ({1'b0, addr_i} < win_end);

    assert_empty_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.limit == '0) |-> !in_window_o);

    assert_bounds_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_base_i || wr_limit_i) |=> $stable(st_q));

endmodule

// File: rtl/prot_tick_timer.sv
module prot_tick_timer #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          irq_o,
    output logic          expire_o
);

    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        logic [TW-1:0] count;
        logic          armed;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       irq_next;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
            st_d.armed = 1'b1;
        end else if (st_q.armed && (st_q.count != '0)) begin
            st_d.count = st_q.count - ONE;
        end
        irq_next = st_d.armed && (st_d.count == '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = st_q.armed && (st_q.count == '0);
    assign expire_o = irq_next && !irq_o;

    assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !load_i) |=> irq_o);

    assert_count_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !load_i) |=> $stable(st_q.count));

    assert_reload_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && (load_val_i != '0)) |=> !irq_o);

    assert_no_early_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.armed && (st_q.count > ONE) && !load_i) |=> !irq_o);

endmodule

// File: rtl/prot_guard_unit.sv
module prot_guard_unit
    import prot_pkg::*;
#(
    parameter int AW = 16,
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ext_irq_i,
    input  logic          enter_user_i,
    input  logic          io_req_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic          acc_valid_i,
    input  logic [AW-1:0] acc_addr_i,
    output logic          user_mode_o,
    output logic          acc_permit_o,
    output logic          prot_fault_o,
    output logic          timer_irq_o
);

    typedef struct packed {
        logic fault;
    } guard_state_t;

    guard_state_t st_d, st_q;

    logic          user_mode;
    logic          in_window;
    logic          priv_attempt;
    logic          priv_fault;
    logic          range_fault;
    logic          write_ok;
    logic          tmr_expire;
    logic          trap;
    logic [TW-1:0] tmr_val;

    // The timer load value is taken from the write data; the width
    // relation between timer and address picks the variant.
    generate
        if (TW <= AW) begin : g_tmr_slice
            assign tmr_val = wr_data_i[TW-1:0];
        end else begin : g_tmr_extend
            assign tmr_val = {{(TW-AW){1'b0}}, wr_data_i};
        end
    endgenerate

    always_comb begin
        priv_attempt = wr_en_i && (wr_sel_i != SEL_NONE);
        priv_fault   = user_mode && (priv_attempt || io_req_i);
        range_fault  = user_mode && acc_valid_i && !in_window;
        write_ok     = !user_mode && priv_attempt;
        st_d         = st_q;
        st_d.fault   = priv_fault || range_fault;
        trap         = st_d.fault || ext_irq_i || tmr_expire;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    prot_mode_ctrl u_mode (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .trap_i       (trap),
        .enter_user_i (enter_user_i),
        .user_o       (user_mode)
    );

    prot_bound_chk #(.AW(AW)) u_bound (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_base_i   (write_ok && (wr_sel_i == SEL_BASE)),
        .wr_limit_i  (write_ok && (wr_sel_i == SEL_LIMIT)),
        .wr_data_i   (wr_data_i),
        .addr_i      (acc_addr_i),
        .in_window_o (in_window)
    );

    prot_tick_timer #(.TW(TW)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (write_ok && (wr_sel_i == SEL_TIMER)),
        .load_val_i (tmr_val),
        .irq_o      (timer_irq_o),
        .expire_o   (tmr_expire)
    );

    assign user_mode_o  = user_mode;
    assign prot_fault_o = st_q.fault;
    assign acc_permit_o = acc_valid_i && (!user_mode || in_window);

    assert_fault_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_fault_o |=> !prot_fault_o);

    assert_fault_monitor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_fault_o |-> !user_mode_o);

    assert_monitor_permit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && !user_mode_o) |-> acc_permit_o);

    assert_idle_no_permit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |-> !acc_permit_o);

    assert_priv_write_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_mode_o && wr_en_i && (wr_sel_i != SEL_NONE)) |=> prot_fault_o);

    assert_io_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_mode_o && io_req_i) |=> prot_fault_o);

    assert_monitor_no_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !user_mode_o |=> !prot_fault_o);

    assert_expiry_monitor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timer_irq_o) |-> !user_mode_o);

endmodule

// File: tb/test_prot_guard_unit.sv
module test_prot_guard_unit;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          ext_irq = 1'b0;
    logic          enter_user = 1'b0;
    logic          io_req = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [AW-1:0] wr_data = '0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          user_mode, permit, fault, irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prot_guard_unit #(.AW(AW), .TW(16)) i_prot_guard_unit (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .ext_irq_i    (ext_irq),
        .enter_user_i (enter_user),
        .io_req_i     (io_req),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .acc_valid_i  (acc_valid),
        .acc_addr_i   (acc_addr),
        .user_mode_o  (user_mode),
        .acc_permit_o (permit),
        .prot_fault_o (fault),
        .timer_irq_o  (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic go_user();
        enter_user = 1'b1;
        step();
        enter_user = 1'b0;
        chk("R7 enter user", user_mode, 1);
    endtask

    task automatic user_access(input logic [AW-1:0] a, input bit exp, input string req);
        go_user();
        acc_valid = 1'b1; acc_addr = a;
        #1;
        chk(req, permit, exp);
        step();
        acc_valid = 1'b0;
        chk({req, " R4 fault"}, fault, !exp);
        chk({req, " R4 mode"}, user_mode, exp);
        if (!exp) begin
            step();
            chk("R4 fault one cycle", fault, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 mode", user_mode, 0);
        chk("R1 fault", fault, 0);
        chk("R1 irq", irq, 0);
        chk("R11 idle permit", permit, 0);
    endtask

    task automatic t_monitor();
        acc_valid = 1'b1; acc_addr = 16'hFFFF;
        #1; chk("R2 permit top", permit, 1);
        acc_addr = 16'h0000;
        #1; chk("R2 permit zero", permit, 1);
        step();
        acc_valid = 1'b0;
        chk("R2 no fault", fault, 0);
        chk("R2 still monitor", user_mode, 0);
        // reset window has size 0
        user_access(16'h0000, 1'b0, "R1 R3 empty window");
    endtask

    task automatic t_window();
        wr(2'd0, 16'h1000);
        wr(2'd1, 16'h0100);
        chk("R5 monitor write no fault", fault, 0);
        user_access(16'h0FFF, 1'b0, "R3 below origin");
        user_access(16'h1000, 1'b1, "R3 at origin");
        user_access(16'h10FF, 1'b1, "R3 last legal");
        user_access(16'h1100, 1'b0, "R3 at end");
        go_user();
        #1; chk("R11 user idle permit", permit, 0);
        step();
        chk("R11 user idle no fault", fault, 0);
        chk("R11 user stays", user_mode, 1);
        ext_irq = 1'b1; step(); ext_irq = 1'b0;
    endtask

    task automatic t_wrap();
        wr(2'd0, 16'hFFF0);
        wr(2'd1, 16'h0020);
        user_access(16'hFFFF, 1'b1, "R3 wide sum top");
        user_access(16'h0005, 1'b0, "R3 no wrap low");
        wr(2'd0, 16'h1000);
        wr(2'd1, 16'h0100);
    endtask

    task automatic t_priv_write();
        go_user();
        wr(2'd0, 16'h3000);
        chk("R5 origin write fault", fault, 1);
        chk("R5 origin write monitor", user_mode, 0);
        step();
        chk("R5 fault one cycle", fault, 0);
        go_user();
        wr(2'd1, 16'h0000);
        chk("R5 size write fault", fault, 1);
        go_user();
        wr(2'd3, 16'h5555);
        chk("R5 select 3 no fault", fault, 0);
        chk("R5 select 3 stays user", user_mode, 1);
        ext_irq = 1'b1; step(); ext_irq = 1'b0;
        user_access(16'h1000, 1'b1, "R5 origin kept");
        user_access(16'h10FF, 1'b1, "R5 size kept");
        user_access(16'h3000, 1'b0, "R5 new origin refused");
    endtask

    task automatic t_io();
        go_user();
        io_req = 1'b1; step(); io_req = 1'b0;
        chk("R6 io fault", fault, 1);
        chk("R6 io monitor", user_mode, 0);
        io_req = 1'b1; step(); io_req = 1'b0;
        chk("R6 monitor io no fault", fault, 0);
    endtask

    task automatic t_mode();
        go_user();
        enter_user = 1'b1; step(); enter_user = 1'b0;
        chk("R7 enter while user", user_mode, 1);
        ext_irq = 1'b1; step(); ext_irq = 1'b0;
        chk("R7 irq to monitor", user_mode, 0);
        chk("R7 irq no fault", fault, 0);
        ext_irq = 1'b1; enter_user = 1'b1; step();
        ext_irq = 1'b0; enter_user = 1'b0;
        chk("R7 irq wins", user_mode, 0);
    endtask

    task automatic t_timer();
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd5; enter_user = 1'b1;
        step();
        wr_en = 1'b0; wr_sel = 2'd3; enter_user = 1'b0;
        chk("R8 load no irq", irq, 0);
        chk("R8 user running", user_mode, 1);
        for (int k = 1; k < 5; k++) begin
            step();
            chk("R8 counting", irq, 0);
            chk("R8 still user", user_mode, 1);
        end
        step();
        chk("R8 expiry", irq, 1);
        chk("R10 expiry monitor", user_mode, 0);
        repeat (6) step();
        chk("R9 irq held", irq, 1);
        go_user();
        wr(2'd2, 16'd9);
        chk("R5 timer write fault", fault, 1);
        chk("R5 timer unchanged", irq, 1);
        wr(2'd2, 16'd3);
        chk("R9 reload clears", irq, 0);
        step(); chk("R8 second count", irq, 0);
        step(); chk("R8 second count", irq, 0);
        step(); chk("R8 second expiry", irq, 1);
    endtask

    initial begin
        repeat (3) step();
        rst_ni = 1'b1;
        #1;
        t_reset();
        step();
        t_reset();
        t_monitor();
        t_window();
        t_wrap();
        t_priv_write();
        t_io();
        t_mode();
        t_timer();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule